// File: doc/BRIEF.md
# Folded Symmetric Lowpass FIR Filter

This block is a 31-tap fixed-point FIR filter. It accepts one signed 8-bit sample per clock and produces one filtered result per clock. Because a linear-phase coefficient set is mirror-symmetric, the two samples that share a coefficient are added before they are multiplied. This needs only sixteen multipliers: fifteen for the paired taps and one for the unpaired centre tap.

A sample enters the block together with an input valid strobe. When the strobe is low, the tap chain freezes. Each accepted sample produces exactly one result, which comes out with its own valid strobe a fixed number of cycles later. The result is kept at full precision, so no input pattern can overflow it.

The sixteen distinct coefficients are a parameter. By default they form a Hamming-windowed lowpass with a 1 MHz cutoff at a 16 MHz sample rate, scaled so that 2048 represents unity.

Top module: `fir_sym31`

## Requirements
- R1: While the asynchronous active-high reset `rst` is high, every tap-chain stage, the output valid strobe and the output word are zero. After reset, the first result depends only on the samples accepted since reset.
- R2: On each clock edge with `in_vld` high, the new sample enters stage 0 and every stage k>0 takes the former value of stage k-1.
- R3: On a clock edge with `in_vld` low, the tap chain keeps its contents and `in_data` has no effect on any later result.
- R4: Samples and coefficients are signed two's complement. Each result equals sum over k=0..14 of c[k]*(x[k]+x[30-k]), plus c[15]*x[15]. Here x[k] is stage k and c[k] is bits [12k+11:12k] of the `COEF` parameter.
- R5: A sample accepted on edge E produces a result with `out_vld` high in exactly the cycle that follows edge E+2. `out_vld` is high in no other cycle, and `out_data` changes only when `out_vld` rises or stays high.
- R6: The output is 26 bits wide and exact for every input pattern, including full-scale samples aligned with the coefficient signs.
- R7: A unit sample followed by zeros yields results equal to c[0], c[1], …, c[15], c[14], …, c[0], in that order.
- R8: The default coefficients, c[0..15], are -1, -4, -8, -13, -17, -18, -14, 0, 21, 52, 93, 138, 183, 221, 247, 256. A steady input of 64 therefore settles to 129024.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active high |
| in_vld | input | 1 | Input sample valid |
| in_data | input | 8 | Signed input sample |
| out_vld | output | 1 | Result valid |
| out_data | output | 26 | Signed full-precision result |

## Verification
The hardest state to reach from the ports is a tap chain in which all 31 stages hold full-scale values, each with the sign that drives the sum to its largest magnitude. This is the only state that tests the 26-bit headroom. The stimulus builds it by feeding 31 samples chosen from the sign of each tap's coefficient, oldest tap first, and then feeding the opposite pattern. A second case that is hard to reach is a reset that arrives while results are still in flight. The bench raises reset between edges with the pipeline full. It then feeds one isolated sample, whose result would reveal any stage that reset failed to clear.

// File: rtl/fir_sym31.sv
module fir_sym31 #(
  parameter int DW   = 8,
  parameter int CW   = 12,
  parameter int NTAP = 31,
  parameter int OW   = DW + 1 + CW + $clog2((NTAP + 1) / 2) + 1,
  parameter logic [((NTAP + 1) / 2) * CW - 1:0] COEF = {
    12'sd256, 12'sd247, 12'sd221, 12'sd183, 12'sd138, 12'sd93, 12'sd52, 12'sd21,
    12'sd0, -12'sd14, -12'sd18, -12'sd17, -12'sd13, -12'sd8, -12'sd4, -12'sd1}
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_data
);
  localparam int NU  = (NTAP + 1) / 2;
  localparam int MID = NU - 1;
  localparam int PW  = DW + 1;
  localparam int MW  = PW + CW;
  localparam int LAT = 3;

  logic [NTAP-1:0][DW-1:0] line;
  logic [LAT-1:0]          vpipe;
  logic signed [MW-1:0]    prod_q [NU];
  logic signed [OW-1:0]    acc;

  always_ff @(posedge clk or posedge rst)
    if (rst) line <= '0;
    else if (in_vld) line <= {line[NTAP-2:0], in_data};

  always_ff @(posedge clk or posedge rst)
    if (rst) vpipe <= '0;
    else vpipe <= {vpipe[LAT-2:0], in_vld};

  for (genvar j = 0; j < NU; j++) begin : gen_tap
    logic signed [PW-1:0] pre;
    if (j == MID) begin : g_mid
      assign pre = {line[j][DW-1], line[j]};
    end else begin : g_pair
      assign pre = {line[j][DW-1], line[j]} + {line[NTAP-1-j][DW-1], line[NTAP-1-j]};
    end
    always_ff @(posedge clk or posedge rst)
      if (rst) prod_q[j] <= '0;
      else if (vpipe[0]) prod_q[j] <= MW'(pre) * MW'($signed(COEF[j*CW +: CW]));
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NU; i++) acc = acc + OW'(prod_q[i]);
  end

  always_ff @(posedge clk or posedge rst)
    if (rst) out_data <= '0;
    else if (vpipe[1]) out_data <= acc;

  assign out_vld = vpipe[LAT-1];

  a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> line[0] == $past(in_data));
  a_r2_shift_chain: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> line[NTAP-1:1] == $past(line[NTAP-2:0]));
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(line));
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> ##3 out_vld);
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_vld |-> ##3 !out_vld);
  a_r5_out_steady: assert property (@(posedge clk) disable iff (rst)
    !vpipe[1] |=> $stable(out_data));
endmodule

// File: tb/tb_fir_sym31.sv
module tb_fir_sym31;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [7:0] in_data = '0;
  logic out_vld;
  logic signed [25:0] out_data;

  int total = 0, bad = 0, tnow = 0;
  string req = "R1";
  longint cb [16] = '{-1, -4, -8, -13, -17, -18, -14, 0, 21, 52, 93, 138, 183, 221, 247, 256};
  longint hc [31];
  longint hist [31];
  int exp_t [$];
  longint exp_v [$];

  always #(CLK_P/2) clk = ~clk;

  fir_sym31 dut (.clk(clk), .rst(rst), .in_vld(in_vld), .in_data(in_data),
                 .out_vld(out_vld), .out_data(out_data));

  function automatic void chk(bit ok, string what, longint act, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endfunction

  function automatic void model_clear();
    for (int i = 0; i < 31; i++) hist[i] = 0;
    exp_t.delete();
    exp_v.delete();
  endfunction

  task automatic step(bit v, logic signed [7:0] d);
    longint y;
    @(negedge clk);
    tnow++;
    if (exp_t.size() > 0 && exp_t[0] + 3 == tnow) begin
      chk(out_vld == 1'b1, "out_vld", longint'(out_vld), 1);
      chk(longint'(out_data) == exp_v[0], "out_data", longint'(out_data), exp_v[0]);
      void'(exp_t.pop_front());
      void'(exp_v.pop_front());
    end else begin
      chk(out_vld == 1'b0, "out_vld idle", longint'(out_vld), 0);
    end
    in_vld = v;
    in_data = d;
    if (v) begin
      for (int i = 30; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = longint'(d);
      y = 0;
      for (int i = 0; i < 31; i++) y += hc[i] * hist[i];
      exp_t.push_back(tnow);
      exp_v.push_back(y);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 8'($urandom));
  endtask

  task automatic t_reset_state();
    req = "R1";
    @(negedge clk);
    chk(out_vld == 1'b0, "reset out_vld", longint'(out_vld), 0);
    chk(out_data == 0, "reset out_data", longint'(out_data), 0);
    rst = 1'b0;
    tnow++;
  endtask

  task automatic t_impulse();
    req = "R7";
    step(1'b1, 8'sd1);
    for (int i = 0; i < 30; i++) step(1'b1, 8'sd0);
    drain();
  endtask

  task automatic t_dc();
    longint last;
    req = "R8";
    for (int i = 0; i < 40; i++) step(1'b1, 8'sd64);
    last = exp_v[exp_v.size()-1];
    drain();
    chk(longint'(out_data) == 129024, "dc settle", longint'(out_data), 129024);
    chk(last == 129024, "dc model", last, 129024);
  endtask

  task automatic t_random();
    req = "R4";
    for (int i = 0; i < 60; i++) step(1'b1, 8'($urandom));
    drain();
  endtask

  task automatic t_gaps();
    req = "R3";
    for (int i = 0; i < 100; i++) step(1'(($urandom % 3) == 0), 8'($urandom));
    drain();
  endtask

  task automatic t_isolated();
    req = "R5";
    for (int i = 0; i < 6; i++) begin
      step(1'b1, 8'($urandom));
      for (int k = 0; k < i; k++) step(1'b0, 8'($urandom));
    end
    drain();
  endtask

  task automatic t_extreme();
    req = "R6";
    for (int i = 30; i >= 0; i--) step(1'b1, hc[i] >= 0 ? -8'sd128 : 8'sd127);
    for (int i = 30; i >= 0; i--) step(1'b1, hc[i] >= 0 ? 8'sd127 : -8'sd128);
    drain();
  endtask

  task automatic t_reset_mid();
    req = "R2";
    for (int i = 0; i < 20; i++) step(1'b1, 8'($urandom));
    req = "R1";
    #(CLK_P/4);
    rst = 1'b1;
    #(CLK_P/4);
    chk(out_vld == 1'b0, "mid reset out_vld", longint'(out_vld), 0);
    chk(out_data == 0, "mid reset out_data", longint'(out_data), 0);
    model_clear();
    in_vld = 1'b0;
    @(negedge clk);
    tnow++;
    rst = 1'b0;
    step(1'b1, 8'sd5);
    drain();
  endtask

  initial begin
    for (int k = 0; k < 31; k++) hc[k] = cb[k <= 15 ? k : 30 - k];
    model_clear();
    t_reset_state();
    t_impulse();
    t_dc();
    t_random();
    t_gaps();
    t_isolated();
    t_extreme();
    t_reset_mid();
    chk(exp_t.size() == 0, "pending results", longint'(exp_t.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    total++;
    bad++;
    $display("FAIL R5 watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule